// File: doc/BRIEF.md
# Scan-Gated Command Queue

This block holds converter command words in a small FIFO and releases them toward a downstream command buffer. Only the operating mode held in a 16-bit control word decides when commands may leave. Software loads commands through a push port. A transfer handshake on the far side moves one command per cycle whenever the mode's trigger condition holds. The same control word carries two write-one-to-act bits. The first arms a single scan. The second discards everything still queued. Both always read back as zero.

Single-scan modes move commands only after an arm. The arm drops once the last queued command has left. Continuous modes move commands whenever their trigger level is present and need no arm. Two of the three trigger sources are level-gated by an external trigger pin. Mode changes are guarded. A running queue may only be switched off. Any mode may be selected only while the queue is off. Every rejected write leaves the state unchanged and sets a sticky error flag. A busy/idle status tells software when it is safe to reconfigure.

Top module: `cmdq_scan`

## Requirements
- R1: The control word numbers its bits from the MSB (bit number 0 = value 0x8000). Bit number 5 (0x0400) is the arm bit. Bit number 6 (0x0200) is the invalidate bit. Bit numbers 8 to 11 (mask 0x00F0, bit number 8 being the mode's MSB) hold the mode. A read returns the current mode in that field and zero everywhere else. After reset the mode is 0, the queue is empty and every flag is clear.
- R2: Mode codes are: 0000 off; 0001 software single scan; 0010 low-level gated single scan; 0011 high-level gated single scan; 1001 software continuous; 1010 low-level gated continuous; 1011 high-level gated continuous. Every other code is unknown.
- R3: While the mode is off, a write may select any known code. While the mode is on, the only accepted change is to off. Rewriting the current code is not a change. Any other change, including an unknown code, is ignored, the old mode is kept, and the sticky error flag is set.
- R4: Writing 1 to the arm bit sets the single-scan flag only when the mode before the write is a single-scan mode. It has no effect in the off or continuous modes, and no effect when the flag is already set.
- R5: Writing 1 to the invalidate bit while the mode is off and the status is idle empties the queue, so the next pushed command is the next one transferred. A push in the same cycle is discarded. The same write while the mode is on is ignored, keeps the queued entries, and sets the sticky error flag.
- R6: The queue holds 4 commands of 32 bits in arrival order and shows its occupancy. A push while full is dropped and sets a sticky overflow flag. push_full is high exactly when 4 entries are held.
- R7: xfer_valid is high only when the queue holds data and the mode's gate is open, and xfer_data is then the oldest entry. A command leaves on a cycle with xfer_valid and xfer_ready both high. In a single-scan mode the flag clears on the edge where the transfer leaves the queue empty.
- R8: Low-level gated modes transfer only while trig is 0. High-level gated modes transfer only while trig is 1. Software modes ignore trig.
- R9: Continuous modes transfer without an arm, under the same trigger gating.
- R10: busy is 0 whenever the mode is off. Otherwise busy is 1 while the single-scan flag is set or a transfer is offered.
- R11: Switching the mode to off clears the single-scan flag and stops transfers, while queued entries are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read value |
| push_valid | input | 1 | Push a command this cycle |
| push_data | input | 32 | Command word to push |
| push_full | output | 1 | Queue holds 4 entries |
| trig | input | 1 | External trigger level |
| xfer_valid | output | 1 | A command is offered downstream |
| xfer_data | output | 32 | Oldest queued command |
| xfer_ready | input | 1 | Downstream accepts the offered command |
| level | output | 3 | Number of queued entries |
| scan_armed | output | 1 | Single-scan flag |
| busy | output | 1 | Status: 1 busy, 0 idle |
| err_sticky | output | 1 | A rejected mode or invalidate write occurred |
| ovf_sticky | output | 1 | A push was dropped because the queue was full |

## Verification
Some properties are checked on every cycle. Trigger gating is one: no offer against the wrong level. Mode legality is another: a running mode moves only to off. The arm flag may rise only in a single-scan mode, and it is never set while off or continuous. Status is idle whenever the mode is off. An invalidate empties the queue, a full push raises overflow, and a transfer never comes from an empty queue. The properties cannot show that commands leave in arrival order with the right data. Nor can they show that a rejected write truly preserved entries, or that an invalidate drops exactly the stale commands so a later push comes out first. Those come from the directed scenarios and a random phase, compared against a reference queue every clock.

// File: rtl/cfq_pkg.sv
package cfq_pkg;

    localparam int CTL_W   = 16;
    // Bit numbers in the control word count from the MSB.
    localparam int ARM_BIT = CTL_W - 1 - 5;
    localparam int INV_BIT = CTL_W - 1 - 6;
    localparam int MODE_HI = CTL_W - 1 - 8;
    localparam int MODE_LO = CTL_W - 1 - 11;
    localparam int MODE_W  = MODE_HI - MODE_LO + 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF   = 4'b0000,
        MODE_SW_SS = 4'b0001,
        MODE_LO_SS = 4'b0010,
        MODE_HI_SS = 4'b0011,
        MODE_SW_CS = 4'b1001,
        MODE_LO_CS = 4'b1010,
        MODE_HI_CS = 4'b1011
    } qmode_e;

    typedef struct packed {
        logic              arm;
        logic              inval;
        logic [MODE_W-1:0] mode;
    } ctl_req_t;

    function automatic ctl_req_t decode_ctl(input logic [CTL_W-1:0] w);
        ctl_req_t r;
        r.arm   = w[ARM_BIT];
        r.inval = w[INV_BIT];
        r.mode  = w[MODE_HI:MODE_LO];
        return r;
    endfunction

    function automatic logic [CTL_W-1:0] encode_ctl(input logic [MODE_W-1:0] m);
        logic [CTL_W-1:0] w;
        w = '0;
        w[MODE_HI:MODE_LO] = m;
        return w;
    endfunction

    // Single-scan codes have the top mode bit clear and a nonzero source.
    function automatic logic mode_single(input logic [MODE_W-1:0] m);
        return (m[3:2] == 2'b00) && (m[1:0] != 2'b00);
    endfunction

    // Continuous codes set the top mode bit with the same source field.
    function automatic logic mode_cont(input logic [MODE_W-1:0] m);
        return (m[3:2] == 2'b10) && (m[1:0] != 2'b00);
    endfunction

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        return (m == MODE_OFF) || mode_single(m) || mode_cont(m);
    endfunction

    // Trigger source in the low two mode bits.
    function automatic logic level_pass(input logic [MODE_W-1:0] m, input logic t);
        logic p;
        case (m[1:0])
            2'b01:   p = 1'b1;
            2'b10:   p = ~t;
            2'b11:   p = t;
            default: p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfq_store.sv
module cfq_store #(
    parameter  int DEPTH = 4,
    parameter  int DW    = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             ovf,
    output logic             push_acc
);

    logic [DW-1:0]    slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             pop_acc;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign push_acc = push && !full && !flush;
    assign pop_acc  = pop && !flush;
    assign head     = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_acc) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= step_ptr(wr_ptr);
            if (pop_acc)  rd_ptr <= step_ptr(rd_ptr);
            case ({push_acc, pop_acc})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end

    // R6: a push against a full queue raises overflow
    a_r6_full_raises_ovf: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |=> ovf);

    // R6: a dropped push does not change occupancy
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush && !pop) |=> (count == $past(count)));

    // R5: an accepted invalidate leaves the queue empty
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    // R7: the transfer side never pops an empty queue
    a_r7_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/cfq_ctl.sv
module cfq_ctl
    import cfq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_word,
    input  logic             busy,
    input  logic             scan_done,
    output qmode_e           mode,
    output logic             armed,
    output logic             flush,
    output logic             err
);

    ctl_req_t req;
    logic     mode_chg;
    logic     mode_ok;
    logic     inval_ok;
    logic     arm_ok;
    logic     go_off;

    assign req = decode_ctl(wr_word);

    always_comb begin
        mode_chg = wr_en && (req.mode != mode);
        if (mode == MODE_OFF) mode_ok = mode_known(req.mode);
        else                  mode_ok = (req.mode == MODE_OFF);
        inval_ok = (mode == MODE_OFF) && !busy;
        arm_ok   = wr_en && req.arm && mode_single(mode) && !armed;
        go_off   = mode_chg && mode_ok && (req.mode == MODE_OFF);
    end

    assign flush = wr_en && req.inval && inval_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= MODE_OFF;
            armed <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (mode_chg && mode_ok) mode <= qmode_e'(req.mode);
            if ((mode_chg && !mode_ok) || (wr_en && req.inval && !inval_ok))
                err <= 1'b1;
            if (go_off)         armed <= 1'b0;
            else if (arm_ok)    armed <= 1'b1;
            else if (scan_done) armed <= 1'b0;
        end
    end

    // R3: a running mode may only move to off
    a_r3_exit_only_to_off: assert property (@(posedge clk) disable iff (rst)
        (($past(mode) != MODE_OFF) && (mode != $past(mode))) |-> (mode == MODE_OFF));

    // R3: an unknown code written while off is refused and flagged
    a_r3_unknown_code: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (mode == MODE_OFF) && !mode_known(req.mode)) |=> ((mode == MODE_OFF) && err));

    // R4: the arm flag can only rise in a single-scan mode
    a_r4_arm_in_single: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> mode_single(mode));

    // R5: invalidate while running is refused and flagged
    a_r5_live_inval_flagged: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.inval && (mode != MODE_OFF)) |=> err);

    // R11: with the mode off the arm flag is clear
    a_r11_off_unarmed: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |-> !armed);

endmodule

// File: rtl/cfq_gate.sv
module cfq_gate
    import cfq_pkg::*;
(
    input  qmode_e mode,
    input  logic   armed,
    input  logic   trig,
    input  logic   has_data,
    output logic   xfer_en,
    output logic   busy
);

    logic lvl_ok;
    logic scan_ok;

    always_comb begin
        lvl_ok  = level_pass(mode, trig);
        scan_ok = mode_cont(mode) || (mode_single(mode) && armed);
        xfer_en = lvl_ok && scan_ok && has_data;
        busy    = (mode != MODE_OFF) && (armed || xfer_en);
    end

endmodule

// File: rtl/cmdq_scan.sv
module cmdq_scan
    import cfq_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [15:0]       ctl_wdata,
    output logic [15:0]       ctl_rdata,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_full,
    input  logic              trig,
    output logic              xfer_valid,
    output logic [DATA_W-1:0] xfer_data,
    input  logic              xfer_ready,
    output logic [CNT_W-1:0]  level,
    output logic              scan_armed,
    output logic              busy,
    output logic              err_sticky,
    output logic              ovf_sticky
);

    qmode_e mode;
    logic   armed;
    logic   flush;
    logic   fire;
    logic   push_acc;
    logic   scan_done;

    assign fire      = xfer_valid && xfer_ready;
    assign scan_done = fire && mode_single(mode) && (level == CNT_W'(1)) && !push_acc;

    cfq_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ctl_we),
        .wr_word   (ctl_wdata),
        .busy      (busy),
        .scan_done (scan_done),
        .mode      (mode),
        .armed     (armed),
        .flush     (flush),
        .err       (err_sticky)
    );

    cfq_store #(.DEPTH(DEPTH), .DW(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (fire),
        .flush     (flush),
        .head      (xfer_data),
        .count     (level),
        .full      (push_full),
        .ovf       (ovf_sticky),
        .push_acc  (push_acc)
    );

    cfq_gate u_gate (
        .mode     (mode),
        .armed    (armed),
        .trig     (trig),
        .has_data (level != '0),
        .xfer_en  (xfer_valid),
        .busy     (busy)
    );

    assign ctl_rdata  = encode_ctl(mode);
    assign scan_armed = armed;

    // R8: low-level gating never offers while trig is high
    a_r8_low_gate: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && ((mode == MODE_LO_SS) || (mode == MODE_LO_CS))) |-> !trig);

    // R8: high-level gating never offers while trig is low
    a_r8_high_gate: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && ((mode == MODE_HI_SS) || (mode == MODE_HI_CS))) |-> trig);

    // R7: single-scan offers need the arm flag
    a_r7_single_needs_arm: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && mode_single(mode)) |-> scan_armed);

    // R7: the transfer that empties the queue ends the scan
    a_r7_scan_ends: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_armed);

    // R9: continuous modes never hold the arm flag
    a_r9_cont_unarmed: assert property (@(posedge clk) disable iff (rst)
        mode_cont(mode) |-> !scan_armed);

    // R10: off means idle
    a_r10_off_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |-> !busy);

endmodule

// File: tb/sim_cmdq_scan.sv
module sim_cmdq_scan;

    localparam int DW    = 32;
    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ctl_we = 1'b0;
    logic [15:0]      ctl_wdata = '0;
    logic [15:0]      ctl_rdata;
    logic             push_valid = 1'b0;
    logic [DW-1:0]    push_data = '0;
    logic             push_full;
    logic             trig = 1'b0;
    logic             xfer_valid;
    logic [DW-1:0]    xfer_data;
    logic             xfer_ready = 1'b0;
    logic [CNT_W-1:0] level;
    logic             scan_armed;
    logic             busy;
    logic             err_sticky;
    logic             ovf_sticky;

    always #5 clk = ~clk;

    cmdq_scan #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .push_valid(push_valid), .push_data(push_data),
        .push_full(push_full), .trig(trig), .xfer_valid(xfer_valid),
        .xfer_data(xfer_data), .xfer_ready(xfer_ready), .level(level),
        .scan_armed(scan_armed), .busy(busy), .err_sticky(err_sticky),
        .ovf_sticky(ovf_sticky)
    );

    int    compared   = 0;
    int    mismatched = 0;
    int    cycles     = 0;
    bit    finished   = 0;
    string cur_req    = "R1";

    // ---------------- reference model ----------------
    int unsigned mq[$];
    logic [3:0]  m_mode = 4'd0;
    bit          m_arm = 0, m_err = 0, m_ovf = 0;

    function automatic bit ref_single(input logic [3:0] m);
        return (m == 4'd1) || (m == 4'd2) || (m == 4'd3);
    endfunction

    function automatic bit ref_cont(input logic [3:0] m);
        return (m == 4'd9) || (m == 4'd10) || (m == 4'd11);
    endfunction

    function automatic bit ref_valid();
        bit open;
        case (m_mode)
            4'd1:    open = m_arm;
            4'd2:    open = m_arm && !trig;
            4'd3:    open = m_arm && trig;
            4'd9:    open = 1;
            4'd10:   open = !trig;
            4'd11:   open = trig;
            default: open = 0;
        endcase
        return open && (mq.size() > 0);
    endfunction

    function automatic bit ref_busy();
        return (m_mode != 4'd0) && (m_arm || ref_valid());
    endfunction

    always @(posedge clk) begin
        bit fire, inval_ok, dis_now;
        logic [3:0] om, nm;
        int pre;
        if (rst) begin
            mq.delete();
            m_mode = 4'd0; m_arm = 0; m_err = 0; m_ovf = 0;
        end else begin
            om = m_mode; pre = mq.size();
            fire = ref_valid() && xfer_ready;
            inval_ok = 0; dis_now = 0;
            if (ctl_we) begin
                nm = ctl_wdata[7:4];
                if (nm != om) begin
                    if ((om == 4'd0 && (nm == 4'd0 || ref_single(nm) || ref_cont(nm))) ||
                        (om != 4'd0 && nm == 4'd0)) begin
                        m_mode = nm;
                        if (nm == 4'd0) dis_now = 1;
                    end else m_err = 1;
                end
                if (ctl_wdata[10] && ref_single(om)) m_arm = 1;
                if (ctl_wdata[9]) begin
                    if (om == 4'd0) inval_ok = 1;
                    else            m_err = 1;
                end
            end
            if (inval_ok) mq.delete();
            else begin
                if (fire) void'(mq.pop_front());
                if (push_valid) begin
                    if (pre < DEPTH) mq.push_back(push_data);
                    else             m_ovf = 1;
                end
                if (fire && ref_single(om) && mq.size() == 0) m_arm = 0;
            end
            if (dis_now) m_arm = 0;
        end
    end

    task automatic expect_v(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            expect_v(cur_req, "rdata", 32'(ctl_rdata), 32'({8'h00, m_mode, 4'h0}));
            expect_v(cur_req, "xfer_valid", 32'(xfer_valid), 32'(ref_valid()));
            if (ref_valid()) expect_v(cur_req, "xfer_data", xfer_data, mq[0]);
            expect_v(cur_req, "level", 32'(level), 32'(mq.size()));
            expect_v(cur_req, "push_full", 32'(push_full), 32'(mq.size() == DEPTH));
            expect_v(cur_req, "armed", 32'(scan_armed), 32'(m_arm));
            expect_v(cur_req, "busy", 32'(busy), 32'(ref_busy()));
            expect_v(cur_req, "err", 32'(err_sticky), 32'(m_err));
            expect_v(cur_req, "ovf", 32'(ovf_sticky), 32'(m_ovf));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic nxt();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) nxt();
    endtask

    task automatic wr(input logic [15:0] w);
        ctl_we = 1'b1; ctl_wdata = w; nxt(); ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic push(input logic [31:0] d);
        push_valid = 1'b1; push_data = d; nxt(); push_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; idle(2); rst = 1'b0;
    endtask

    task automatic look(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        expect_v(req, what, act, exp);
    endtask

    initial begin
        nxt();
        idle(2);
        rst = 1'b0;
        #1;
        // R1: reset state
        look("R1", "reset rdata", 32'(ctl_rdata), 32'h0);
        look("R1", "reset level", 32'(level), 32'h0);
        look("R1", "reset flags", {28'h0, scan_armed, busy, err_sticky, ovf_sticky}, 32'h0);

        // R1: arm+invalidate bits read as zero, mode field placement
        cur_req = "R1";
        wr(16'h0610);
        #1;
        look("R1", "mode readback", 32'(ctl_rdata), 32'h0010);
        look("R4", "arm while off ignored", 32'(scan_armed), 32'h0);
        wr(16'h0000);

        // R6: fill and overflow
        cur_req = "R6";
        push(32'hA000_0001); push(32'hA000_0002); push(32'hA000_0003);
        push(32'hA000_0004); push(32'hA000_0005);
        #1;
        look("R6", "level full", 32'(level), 32'd4);
        look("R6", "overflow", 32'(ovf_sticky), 32'h1);
        look("R6", "push_full", 32'(push_full), 32'h1);

        // R7: software single scan
        cur_req = "R7";
        xfer_ready = 1'b1;
        wr(16'h0010);
        #1;
        look("R7", "no offer before arm", 32'(xfer_valid), 32'h0);
        wr(16'h0410);
        #1;
        look("R7", "offer after arm", 32'(xfer_valid), 32'h1);
        look("R7", "oldest first", xfer_data, 32'hA000_0001);
        idle(4);
        #1;
        look("R7", "scan flag cleared", 32'(scan_armed), 32'h0);
        look("R7", "drained", 32'(level), 32'h0);
        look("R10", "idle after scan", 32'(busy), 32'h0);

        // R11: disable clears arm, keeps entries
        cur_req = "R11";
        xfer_ready = 1'b0;
        push(32'hB000_0001); push(32'hB000_0002);
        wr(16'h0410);
        #1;
        look("R10", "busy while armed", 32'(busy), 32'h1);
        wr(16'h0000);
        #1;
        look("R11", "arm cleared", 32'(scan_armed), 32'h0);
        look("R11", "no offer", 32'(xfer_valid), 32'h0);
        look("R11", "entries kept", 32'(level), 32'd2);

        // R5: invalidate while off, then refill
        cur_req = "R5";
        wr(16'h0200);
        #1;
        look("R5", "invalidate empties", 32'(level), 32'h0);
        push(32'hC000_000F);
        wr(16'h0010);
        xfer_ready = 1'b1;
        wr(16'h0410);
        #1;
        look("R5", "new head after invalidate", xfer_data, 32'hC000_000F);
        idle(1);
        push(32'hC000_0010);
        wr(16'h0210);
        #1;
        look("R5", "live invalidate flagged", 32'(err_sticky), 32'h1);
        look("R5", "live invalidate kept entry", 32'(level), 32'h1);
        do_reset();

        // R3: mode legality
        cur_req = "R3";
        wr(16'h0020);
        wr(16'h0030);
        #1;
        look("R3", "running change refused", 32'(ctl_rdata), 32'h0020);
        look("R3", "error raised", 32'(err_sticky), 32'h1);
        wr(16'h0000);
        #1;
        look("R3", "change to off accepted", 32'(ctl_rdata), 32'h0);
        do_reset();
        wr(16'h0050);
        #1;
        look("R3", "unknown code refused", 32'(ctl_rdata), 32'h0);
        look("R3", "unknown code flagged", 32'(err_sticky), 32'h1);
        do_reset();

        // R8: gated single scans
        cur_req = "R8";
        xfer_ready = 1'b1;
        wr(16'h0020);
        trig = 1'b1;
        push(32'hD000_0001); push(32'hD000_0002);
        wr(16'h0420);
        #1;
        look("R8", "low gate closed by high trig", 32'(xfer_valid), 32'h0);
        trig = 1'b0;
        #1;
        look("R8", "low gate open", 32'(xfer_valid), 32'h1);
        idle(2);
        wr(16'h0000);
        wr(16'h0030);
        push(32'hD000_0003);
        wr(16'h0430);
        #1;
        look("R8", "high gate closed by low trig", 32'(xfer_valid), 32'h0);
        trig = 1'b1;
        #1;
        look("R8", "high gate open", 32'(xfer_valid), 32'h1);
        idle(1);
        wr(16'h0000);

        // R4 / R9: continuous modes ignore arming
        cur_req = "R9";
        xfer_ready = 1'b0;
        wr(16'h0090);
        push(32'hE000_0001);
        wr(16'h0490);
        #1;
        look("R4", "arm ignored in continuous", 32'(scan_armed), 32'h0);
        look("R9", "offer without arm", 32'(xfer_valid), 32'h1);
        xfer_ready = 1'b1;
        idle(1);
        wr(16'h0000);
        wr(16'h00A0);
        trig = 1'b1;
        push(32'hE000_0002);
        #1;
        look("R9", "continuous low gate closed", 32'(xfer_valid), 32'h0);
        trig = 1'b0;
        #1;
        look("R9", "continuous low gate open", 32'(xfer_valid), 32'h1);
        idle(1);
        wr(16'h0000);

        // R10: armed on empty queue is busy
        cur_req = "R10";
        wr(16'h0010);
        wr(16'h0410);
        wr(16'h0410);
        #1;
        look("R10", "armed empty busy", 32'(busy), 32'h1);
        wr(16'h0000);
        #1;
        look("R10", "off idle", 32'(busy), 32'h0);
        do_reset();

        // R2: random mix of codes, pushes, triggers and handshakes
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            logic [3:0] codes [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd9, 4'd10, 4'd11, 4'd6};
            logic [15:0] w;
            w = 16'($urandom());
            w[7:4] = codes[$urandom_range(0, 7)];
            if ($urandom_range(0, 3) == 0) w[7:4] = 4'd0;
            ctl_we     = ($urandom_range(0, 7) == 0);
            ctl_wdata  = w;
            push_valid = ($urandom_range(0, 2) == 0);
            push_data  = $urandom();
            trig       = 1'($urandom());
            xfer_ready = ($urandom_range(0, 3) != 0);
            nxt();
            if (i % 150 == 149) begin
                ctl_we = 1'b0; push_valid = 1'b0;
                do_reset();
            end
        end
        ctl_we = 1'b0; push_valid = 1'b0;
        idle(2);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule